// File: doc/BRIEF.md
# Gigabit Ethernet Transmit Ordered-Set Generator

This block sits directly in front of the 8b/10b encoder of a gigabit Ethernet PCS transmitter. Each cycle it accepts one 8-bit code group with a control flag, and it emits one code group to the encoder on a registered output. After the synchronous reset is released, it sends a fixed preamble of three /K28.5/ commas. While it does so, it holds off user input with a ready signal.

After the preamble it forwards user code groups with one cycle of latency. It also rewrites them in three ways. First, it keeps every /K28.5/ on an even code-group position. A comma that arrives on an odd position is delayed by one cycle behind a pad data group. Second, it rewrites the data group of every idle ordered set (a /K28.5/ followed by a data group) into /I1/ or /I2/, so that running disparity is negative once the set has been sent. Third, it passes the two configuration ordered sets through unchanged.

Running disparity is not provided from outside. The block follows it by applying the disparity effect of every code group it emits.

Top module: `ge_tx_ordset_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the output becomes data byte 0x00 with out_k low, and in_ready is low.
- R2: After reset is released, the first three emitted code groups are /K28.5/ (byte 0xBC with out_k high). The fourth is derived from the first input accepted.
- R3: in_ready is low at the first three clock edges after reset release and high at the fourth. Input presented while in_ready is low has no effect on the output.
- R4: A data group that follows an emitted /K28.5/ and is not a configuration code is replaced. It becomes /D5.6/ (0xC5) when running disparity was positive before that comma, and /D16.2/ (0x50) when it was negative.
- R5: Running disparity is negative at reset and positive after the preamble. The first idle after reset therefore becomes /I1/ (data 0xC5), and back-to-back idles after it become /I2/ (data 0x50).
- R6: A data group 0xB5 (/D21.5/) that follows an emitted /K28.5/ passes through unchanged.
- R7: A data group 0x42 (/D2.2/) that follows an emitted /K28.5/ passes through unchanged.
- R8: User positions count from 0 after the preamble, and /K28.5/ is emitted only on even positions. A /K28.5/ input on an odd position produces a pad data group. The pad is the R4 replacement when the previous output was /K28.5/, and 0x50 otherwise. The /K28.5/ follows on the next cycle, and in_ready is low for that one cycle.
- R9: All other code groups, including control codes other than /K28.5/, are emitted unchanged one cycle after they are accepted. Data bytes are {y[2:0], x[4:0]}.
- R10: Running disparity flips on a code group exactly when one of its sub-blocks is unbalanced. The 6-bit sub-block is unbalanced for x in {0,1,2,4,8,15,16,23,24,27,29,30,31}, and also for control x=28. The 4-bit sub-block is unbalanced for y in {0,4,7}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one code group per cycle |
| rst_n | input | 1 | Synchronous active-low digital reset |
| in_data | input | 8 | User code group, {y, x} |
| in_k | input | 1 | High when in_data is a control code group |
| in_ready | output | 1 | High when in_data/in_k are consumed this cycle |
| out_data | output | 8 | Emitted code group to the encoder |
| out_k | output | 1 | Control flag of the emitted code group |

## Verification
A disparity register that drifts from the true value does not show up at once. It shows at the data group of the next idle ordered set, which then carries the wrong one of /D5.6/ and /D16.2/. The stimulus therefore puts data groups with unbalanced sub-blocks before idles, so that a drift appears within a few cycles. A wrong position parity shows as a /K28.5/ on an odd position, or as a missing or extra pad, on the next comma that is offered. A wrong preamble count shows in the first four cycles after reset release, both in the commas emitted and in the timing of in_ready.

// File: rtl/ge_osg_pkg.sv
// Shared constants and the disparity rule for the ordered-set generator.
// Assumes code groups are carried as {y[2:0], x[4:0]}.
package ge_osg_pkg;

    localparam logic [7:0] CG_K28_5 = 8'hBC;
    localparam logic [7:0] CG_D5_6  = 8'hC5;
    localparam logic [7:0] CG_D16_2 = 8'h50;
    localparam logic [7:0] CG_D21_5 = 8'hB5;
    localparam logic [7:0] CG_D2_2  = 8'h42;
    localparam logic [7:0] CG_RESET = 8'h00;

    // x values whose 6-bit sub-block carries an unequal count of ones and zeros
    localparam logic [31:0] SIX_UNBAL = 32'hE981_8117;
    // y values whose 4-bit sub-block is unbalanced: 0, 4, 7
    localparam logic [7:0]  FOUR_UNBAL = 8'h91;

    // True when emitting this code group inverts running disparity
    function automatic logic flips_rd(input logic [7:0] code, input logic is_k);
        logic six;
        logic four;
        six  = (is_k && code[4:0] == 5'd28) ? 1'b1 : SIX_UNBAL[code[4:0]];
        four = FOUR_UNBAL[code[7:5]];
        return six ^ four;
    endfunction

endpackage

// File: rtl/ge_osg_preamble.sv
// Preamble sequencer: after reset it stays active for LEN cycles, one
// comma per cycle, then remains idle until the next reset.
module ge_osg_preamble #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Count emitted preamble commas, saturating at LEN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LEN)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active = (cnt_q != CW'(LEN));
endmodule

// File: rtl/ge_osg_disparity.sv
// Running disparity follower: applies the disparity effect of every code
// group that is being registered onto the output. Low means negative.
module ge_osg_disparity
    import ge_osg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] code,
    input  logic       code_k,
    output logic       rd_pos
);
    // Invert the tracked disparity when the emitted group is unbalanced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos <= 1'b0;
        end else if (flips_rd(code, code_k)) begin
            rd_pos <= ~rd_pos;
        end
    end
endmodule

// File: rtl/ge_osg_select.sv
// Next-output selection: decides the code group for the next cycle and the
// next alignment state. Purely combinational. Assumes the input is consumed
// only when neither the preamble nor a delayed comma is pending.
module ge_osg_select
    import ge_osg_pkg::*;
(
    input  logic       preamble,
    input  logic       pending,
    input  logic       set_open,
    input  logic       pos_odd,
    input  logic       rd_pos,
    input  logic [7:0] in_data,
    input  logic       in_k,
    output logic [7:0] nxt_data,
    output logic       nxt_k,
    output logic       nxt_pending,
    output logic       nxt_open,
    output logic       nxt_odd
);
    logic       is_comma;
    logic       is_cfg;
    logic [7:0] fill;

    assign is_comma = in_k && (in_data == CG_K28_5);
    assign is_cfg   = !in_k && (in_data == CG_D21_5 || in_data == CG_D2_2);
    // After the comma, positive disparity means it was negative before it
    assign fill     = rd_pos ? CG_D16_2 : CG_D5_6;

    // Pick the emitted group and update alignment bookkeeping
    always_comb begin
        nxt_data    = in_data;
        nxt_k       = in_k;
        nxt_pending = 1'b0;
        nxt_open    = 1'b0;
        nxt_odd     = ~pos_odd;
        if (preamble) begin
            nxt_data = CG_K28_5;
            nxt_k    = 1'b1;
            nxt_odd  = 1'b0;
        end else if (pending) begin
            nxt_data = CG_K28_5;
            nxt_k    = 1'b1;
            nxt_open = 1'b1;
        end else if (is_comma && !pos_odd) begin
            nxt_open = 1'b1;
        end else if (is_comma) begin
            nxt_data    = set_open ? fill : CG_D16_2;
            nxt_k       = 1'b0;
            nxt_pending = 1'b1;
        end else if (set_open && !in_k && !is_cfg) begin
            nxt_data = fill;
        end
    end
endmodule

// File: rtl/ge_tx_ordset_gen.sv
// Transmit ordered-set generator, top level. Emits a comma preamble after
// reset, keeps commas on even positions, rewrites idle sets by running
// disparity and passes configuration sets. Output is registered; input is
// consumed at an edge where in_ready is high.
module ge_tx_ordset_gen
    import ge_osg_pkg::*;
#(
    parameter int PRE_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_k,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_k
);
    logic       preamble;
    logic       rd_pos;
    logic       pending_q, open_q, odd_q;
    logic [7:0] nxt_data;
    logic       nxt_k, nxt_pending, nxt_open, nxt_odd;

    ge_osg_preamble #(.LEN(PRE_LEN)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (preamble)
    );

    ge_osg_select u_sel (
        .preamble    (preamble),
        .pending     (pending_q),
        .set_open    (open_q),
        .pos_odd     (odd_q),
        .rd_pos      (rd_pos),
        .in_data     (in_data),
        .in_k        (in_k),
        .nxt_data    (nxt_data),
        .nxt_k       (nxt_k),
        .nxt_pending (nxt_pending),
        .nxt_open    (nxt_open),
        .nxt_odd     (nxt_odd)
    );

    ge_osg_disparity u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (nxt_data),
        .code_k (nxt_k),
        .rd_pos (rd_pos)
    );

    // Register the emitted group and the alignment state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= CG_RESET;
            out_k     <= 1'b0;
            pending_q <= 1'b0;
            open_q    <= 1'b0;
            odd_q     <= 1'b0;
        end else begin
            out_data  <= nxt_data;
            out_k     <= nxt_k;
            pending_q <= nxt_pending;
            open_q    <= nxt_open;
            odd_q     <= nxt_odd;
        end
    end

    assign in_ready = !preamble && !pending_q;
endmodule

// File: rtl/ge_osg_checker.sv
// Port-level checker for the ordered-set generator. It keeps its own count
// of cycles since reset and its own position parity.
module ge_osg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_k
);
    logic [2:0] cyc_q;
    logic       phase_q;
    logic       prev_comma_q;
    logic       out_comma;

    assign out_comma = out_k && (out_data == 8'hBC);

    // Track cycles since release, output parity and the last emitted comma
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q        <= '0;
            phase_q      <= 1'b0;
            prev_comma_q <= 1'b0;
        end else begin
            if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
            if (cyc_q == 3'd4) phase_q <= ~phase_q;
            prev_comma_q <= (cyc_q == 3'd4) && out_comma;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (out_data == 8'h00 && !out_k && !in_ready));

    a_r2_preamble_commas: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd1 && cyc_q <= 3'd3) |-> out_comma);

    a_r3_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q <= 3'd2) |-> !in_ready);

    a_r3_ready_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd3) |-> in_ready);

    a_r8_comma_even: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd4 && out_comma) |-> !phase_q);

    a_r4_idle_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_comma_q && !out_k && out_data != 8'hB5 && out_data != 8'h42)
            |-> (out_data == 8'hC5 || out_data == 8'h50));
endmodule

bind ge_tx_ordset_gen ge_osg_checker u_osg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_k    (out_k)
);

// File: tb/ge_tx_ordset_gen_tb.sv
// Bench for the ordered-set generator: directed corners then seeded random
// streams, compared each cycle with a requirement-level model.
module ge_tx_ordset_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_k = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_k;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    // model state
    bit         m_rd, m_pend, m_open, m_odd;
    int         m_pre;
    logic [7:0] e_data;
    bit         e_k, e_rdy;
    string      e_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ge_tx_ordset_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_k     (in_k),
        .in_ready (in_ready),
        .out_data (out_data),
        .out_k    (out_k)
    );

    // Disparity rule of R10, written as sub-block lists
    function automatic bit b_flip(input logic [7:0] c, input bit k);
        bit six, four;
        six  = (k && c[4:0] == 5'd28) ||
               (c[4:0] inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16,
                               5'd23, 5'd24, 5'd27, 5'd29, 5'd30, 5'd31});
        four = c[7:5] inside {3'd0, 3'd4, 3'd7};
        return six ^ four;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_rd = 0; m_pend = 0; m_open = 0; m_odd = 0; m_pre = 0;
        e_data = 8'h00; e_k = 0; e_rdy = 0;
    endtask

    task automatic m_step(input logic [7:0] d, input bit k);
        bit comma;
        logic [7:0] fill;
        comma = k && d == 8'hBC;
        fill  = m_rd ? 8'h50 : 8'hC5;
        if (m_pre < 3) begin
            e_data = 8'hBC; e_k = 1; m_pre++; e_tag = "R2";
        end else begin
            if (m_pend) begin
                e_data = 8'hBC; e_k = 1; m_pend = 0; m_open = 1; e_tag = "R8";
            end else if (comma && !m_odd) begin
                e_data = 8'hBC; e_k = 1; m_open = 1; e_tag = "R9";
            end else if (comma) begin
                e_data = m_open ? fill : 8'h50; e_k = 0; m_pend = 1; m_open = 0; e_tag = "R8";
            end else if (m_open && !k && d != 8'hB5 && d != 8'h42) begin
                e_data = fill; e_k = 0; m_open = 0; e_tag = "R4";
            end else begin
                e_data = d; e_k = k;
                e_tag = (m_open && !k) ? ((d == 8'hB5) ? "R6" : "R7") : "R9";
                m_open = 0;
            end
            m_odd = !m_odd;
        end
        if (b_flip(e_data, e_k)) m_rd = !m_rd;
        e_rdy = (m_pre >= 3) && !m_pend;
    endtask

    // One cycle: drive, clock, then compare at the following falling edge
    task automatic tick(input logic [7:0] d, input bit k, input string tag_ovr = "");
        in_data = d;
        in_k = k;
        m_step(d, k);
        if (tag_ovr != "") e_tag = tag_ovr;
        @(posedge clk);
        @(negedge clk);
        chk({out_k, out_data} == {e_k, e_data}, e_tag, {out_k, out_data}, {e_k, e_data});
        chk(in_ready == e_rdy, "R3", {8'h00, in_ready}, {8'h00, e_rdy});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(out_data == 8'h00 && !out_k && !in_ready, "R1",
            {out_k, out_data}, 9'h000);
        rst_n = 1;
        m_reset();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        logic [7:0] r;
        s = $urandom(32'h5EED);
        do_reset();
        // preamble, with input that must be ignored (R3)
        tick(8'hBC, 1); tick(8'h42, 0); tick(8'hBC, 1);
        // first idle is /I1/, then /I2/ (R5)
        tick(8'hBC, 1); tick(8'h00, 0, "R5");
        tick(8'hBC, 1); tick(8'h77, 0, "R5");
        tick(8'hBC, 1); tick(8'h13, 0, "R5");
        // configuration sets pass (R6, R7)
        tick(8'hBC, 1); tick(8'hB5, 0);
        tick(8'hBC, 1); tick(8'h42, 0);
        // unbalanced data shifts disparity before an idle (R10)
        tick(8'h50, 0); tick(8'h00, 0); tick(8'hBC, 1); tick(8'h11, 0, "R10");
        tick(8'hE7, 0); tick(8'h3D, 0); tick(8'hBC, 1); tick(8'h11, 0, "R10");
        // comma on odd position (R8)
        tick(8'h00, 0); tick(8'hBC, 1); tick(8'h99, 0); tick(8'h33, 0);
        tick(8'hBC, 1); tick(8'hBC, 1); tick(8'h66, 0); tick(8'h21, 0);
        // other control codes pass (R9)
        tick(8'h1C, 1); tick(8'hF7, 1); tick(8'hA5, 0);
        // second reset mid-stream (R2)
        do_reset();
        repeat (3) tick(8'h5A, 0);
        // seeded random mixture
        for (int i = 0; i < 2500; i++) begin
            r = 8'($urandom);
            case ($urandom % 6)
                0, 1: begin
                    if (r == 8'hB5 || r == 8'h42) r = 8'h00;
                    tick(8'hBC, 1); tick(r, 0);
                end
                2: begin tick(8'hBC, 1); tick(($urandom % 2) ? 8'hB5 : 8'h42, 0); end
                3: tick(r, 0);
                4: tick(($urandom % 2) ? 8'h1C : 8'hF7, 1);
                default: tick(8'hBC, 1);
            endcase
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule